// File: doc/BRIEF.md
# Character Font Memory Fetch Sequencer

This block reads glyph data from an external byte-wide font ROM for a text overlay engine that has two layers: a main layer and a sub layer. A layer asks for one character row by pulsing its request together with a 14-bit character code and a 5-bit raster number. The sequencer then reads the three bytes that make up the 24-dot row (left, centre, right). It puts them together into a 24-bit pixel word and signals a one-cycle valid pulse to the downstream shifter.

Time is cut into read slots of four dot clocks. The slots belong to the main layer and the sub layer in turn, so both layers share the one ROM bus at the same pace. Each slot drives a 21-bit address and an active-low read strobe. The byte the ROM returns is latched on the edge that closes the slot. An external bus-ownership input controls an output-enable signal, so the address and strobe pins can be released to another master while fetching goes on inside the block.

Top module: `font_fetch_seq`

## Requirements
- R1: The ROM address carries the raster number in bits 4:0, code bits 6:0 in address bits 11:5 and code bits 13:7 in address bits 20:14.
- R2: Address bits 13:12 select the byte of the row: left is bit13=0 and bit12=0, centre is bit12=1 and bit13=0, right is bit13=1 and bit12=0. A row is read in the order left, centre, right, and the value 11 never appears during a read.
- R3: A read slot lasts 4 clocks. In a slot that fetches, the strobe is high for the first clock and low for the other three, and the address does not change while the strobe is low. In a slot that does not fetch, the strobe stays high.
- R4: Slots alternate between the main and sub layers. When both layers ask at the same moment, their valid pulses are exactly 4 clocks apart and never coincide.
- R5: Each byte is latched on the clock edge that ends its slot. The pixel output holds left in bits 23:16, centre in 15:8 and right in 7:0, changes only when the third byte is latched, and valid is a one-cycle pulse at that time.
- R6: A request is taken up only at the start of a slot that belongs to its layer. A request that arrives at any other time is held. From the edge that samples the request to the valid pulse takes 20 to 27 clocks.
- R7: A request that arrives while its layer is busy is held and served after the current row. If several such requests arrive, the most recent code and raster are used.
- R8: The output enable takes the value of the bus-ownership input one clock later. Fetching and latching go on normally while the bus is released.
- R9: During synchronous reset the strobe is high, the output enable is low, both valids are low and both pixel words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| main_req | input | 1 | Main layer row request |
| main_code | input | 14 | Main layer character code |
| main_raster | input | 5 | Main layer raster within the cell |
| sub_req | input | 1 | Sub layer row request |
| sub_code | input | 14 | Sub layer character code |
| sub_raster | input | 5 | Sub layer raster within the cell |
| bus_own | input | 1 | High when this block may drive the ROM bus |
| rom_data | input | 8 | Byte returned by the font ROM |
| rom_addr | output | 21 | Font ROM address |
| rom_rd_n | output | 1 | Active-low read strobe |
| rom_oe | output | 1 | Output enable for rom_addr and rom_rd_n |
| main_pix | output | 24 | Main layer row pixels |
| main_valid | output | 1 | Main layer row-complete pulse |
| sub_pix | output | 24 | Sub layer row pixels |
| sub_valid | output | 1 | Sub layer row-complete pulse |

## Verification
The hardest case to reach from the ports is a request that arrives while its own layer is busy, followed by a second request before the first one has been taken up. Only the most recent code may reach the second row. The bench gets there by sending three main requests a few clocks apart, while the first row is still in flight. It then checks that the second valid carries the third code. Requests from the vector table are also separated by varying idle gaps, so they fall on every phase of the slot. This covers both ends of the 20 to 27 clock latency window.

// File: rtl/font_fetch_pkg.sv
package font_fetch_pkg;
  localparam int RASTER_W  = 5;
  localparam int CODE_W    = 14;
  localparam int CODE_LO_W = 7;
  localparam int CODE_HI_W = CODE_W - CODE_LO_W;
  localparam int SEL_W     = 2;
  localparam int ADDR_W    = CODE_HI_W + SEL_W + CODE_LO_W + RASTER_W;
  localparam int BYTE_W    = 8;
  localparam int ROW_BYTES = 3;
  localparam int ROW_W     = BYTE_W * ROW_BYTES;
  localparam int IDX_W     = $clog2(ROW_BYTES);
  localparam int NUM_LANES = 2;

  typedef enum logic {LANE_MAIN = 1'b0, LANE_SUB = 1'b1} lane_e;

  // selector value {bit13, bit12} for byte position in the row
  function automatic logic [SEL_W-1:0] byte_sel(input logic [IDX_W-1:0] idx);
    case (idx)
      IDX_W'(1): byte_sel = 2'b01;
      IDX_W'(2): byte_sel = 2'b10;
      default:   byte_sel = 2'b00;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] make_addr(input logic [CODE_W-1:0]   code,
                                                  input logic [RASTER_W-1:0] raster,
                                                  input logic [IDX_W-1:0]    idx);
    make_addr = {code[CODE_W-1:CODE_LO_W], byte_sel(idx), code[CODE_LO_W-1:0], raster};
  endfunction
endpackage

// File: rtl/font_fetch_slot_timer.sv
module font_fetch_slot_timer #(
  parameter int SLOT_CLKS = 4
) (
  input  logic clk,
  input  logic rst,
  output logic boundary,
  output logic owner
);
  localparam int PH_W = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;

  logic [PH_W-1:0] phase;

  assign boundary = (phase == PH_W'(SLOT_CLKS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      owner <= 1'b1;   // first boundary hands the bus to the main lane
    end else if (boundary) begin
      phase <= '0;
      owner <= ~owner;
    end else begin
      phase <= phase + PH_W'(1);
    end
  end
endmodule

// File: rtl/font_fetch_lane.sv
module font_fetch_lane
  import font_fetch_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                req,
  input  logic [CODE_W-1:0]   code_in,
  input  logic [RASTER_W-1:0] raster_in,
  input  logic                slot_start,
  input  logic                slot_end,
  input  logic [BYTE_W-1:0]   rd_data,
  output logic                will_fetch,
  output logic [ADDR_W-1:0]   start_addr,
  output logic [ROW_W-1:0]    pix,
  output logic                valid
);
  logic                busy;
  logic                pend;
  logic [IDX_W-1:0]    idx;
  logic [CODE_W-1:0]   row_code, hold_code, use_code;
  logic [RASTER_W-1:0] row_raster, hold_raster, use_raster;
  logic [ROW_BYTES-1:0][BYTE_W-1:0] row_buf, assembled;
  logic                take_new;
  logic                last_byte;

  assign take_new   = !busy && (pend || req);
  assign use_code   = req ? code_in   : hold_code;
  assign use_raster = req ? raster_in : hold_raster;
  assign will_fetch = busy || pend || req;
  assign start_addr = busy ? make_addr(row_code, row_raster, idx)
                           : make_addr(use_code, use_raster, '0);
  assign last_byte  = (idx == IDX_W'(ROW_BYTES - 1));

  always_comb begin
    assembled    = row_buf;
    assembled[0] = rd_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      pend        <= 1'b0;
      idx         <= '0;
      row_code    <= '0;
      row_raster  <= '0;
      hold_code   <= '0;
      hold_raster <= '0;
      row_buf     <= '0;
      pix         <= '0;
      valid       <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (slot_end && busy) begin
        if (last_byte) begin
          pix   <= assembled;
          valid <= 1'b1;
          busy  <= 1'b0;
          idx   <= '0;
        end else begin
          row_buf[IDX_W'(ROW_BYTES - 1) - idx] <= rd_data;
          idx <= idx + IDX_W'(1);
        end
      end
      if (slot_start && take_new) begin
        busy       <= 1'b1;
        idx        <= '0;
        row_code   <= use_code;
        row_raster <= use_raster;
        pend       <= 1'b0;
      end else if (req) begin
        pend        <= 1'b1;
        hold_code   <= code_in;
        hold_raster <= raster_in;
      end
    end
  end
endmodule

// File: rtl/font_fetch_seq.sv
module font_fetch_seq
  import font_fetch_pkg::*;
#(
  parameter int SLOT_CLKS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                main_req,
  input  logic [CODE_W-1:0]   main_code,
  input  logic [RASTER_W-1:0] main_raster,
  input  logic                sub_req,
  input  logic [CODE_W-1:0]   sub_code,
  input  logic [RASTER_W-1:0] sub_raster,
  input  logic                bus_own,
  input  logic [BYTE_W-1:0]   rom_data,
  output logic [ADDR_W-1:0]   rom_addr,
  output logic                rom_rd_n,
  output logic                rom_oe,
  output logic [ROW_W-1:0]    main_pix,
  output logic                main_valid,
  output logic [ROW_W-1:0]    sub_pix,
  output logic                sub_valid
);
  logic boundary, owner, nxt_owner, slot_active;
  logic [NUM_LANES-1:0]                req_v, will_v, valid_v;
  logic [NUM_LANES-1:0][CODE_W-1:0]   code_v;
  logic [NUM_LANES-1:0][RASTER_W-1:0] raster_v;
  logic [NUM_LANES-1:0][ADDR_W-1:0]   addr_v;
  logic [NUM_LANES-1:0][ROW_W-1:0]    pix_v;

  assign req_v    = {sub_req, main_req};
  assign code_v   = {sub_code, main_code};
  assign raster_v = {sub_raster, main_raster};
  assign nxt_owner = ~owner;

  font_fetch_slot_timer #(.SLOT_CLKS(SLOT_CLKS)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .boundary (boundary),
    .owner    (owner)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    font_fetch_lane u_lane (
      .clk        (clk),
      .rst        (rst),
      .req        (req_v[g]),
      .code_in    (code_v[g]),
      .raster_in  (raster_v[g]),
      .slot_start (boundary && (owner != 1'(g))),
      .slot_end   (boundary && (owner == 1'(g))),
      .rd_data    (rom_data),
      .will_fetch (will_v[g]),
      .start_addr (addr_v[g]),
      .pix        (pix_v[g]),
      .valid      (valid_v[g])
    );
  end

  assign main_pix   = pix_v[LANE_MAIN];
  assign sub_pix    = pix_v[LANE_SUB];
  assign main_valid = valid_v[LANE_MAIN];
  assign sub_valid  = valid_v[LANE_SUB];

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_addr    <= '0;
      slot_active <= 1'b0;
      rom_rd_n    <= 1'b1;
      rom_oe      <= 1'b0;
    end else begin
      rom_oe <= bus_own;
      if (boundary) begin
        slot_active <= will_v[nxt_owner];
        if (will_v[nxt_owner]) rom_addr <= addr_v[nxt_owner];
        rom_rd_n <= 1'b1;
      end else begin
        rom_rd_n <= ~slot_active;
      end
    end
  end
endmodule

// File: rtl/font_fetch_seq_chk.sv
module font_fetch_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic        bus_own,
  input logic        rom_oe,
  input logic        rom_rd_n,
  input logic [20:0] rom_addr,
  input logic        main_valid,
  input logic        sub_valid
);
  a_r3_addr_setup: assert property (@(posedge clk) disable iff (rst)
    $fell(rom_rd_n) |-> $stable(rom_addr));

  a_r3_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (!rom_rd_n && $past(!rom_rd_n)) |-> $stable(rom_addr));

  a_r3_strobe_width: assert property (@(posedge clk) disable iff (rst)
    (!rom_rd_n && $past(!rom_rd_n) && $past(!rom_rd_n, 2)) |=> rom_rd_n);

  a_r2_sel_legal: assert property (@(posedge clk) disable iff (rst)
    !rom_rd_n |-> (rom_addr[13:12] != 2'b11));

  a_r4_no_dual_valid: assert property (@(posedge clk) disable iff (rst)
    !(main_valid && sub_valid));

  a_r5_main_pulse: assert property (@(posedge clk) disable iff (rst)
    main_valid |=> !main_valid);

  a_r5_sub_pulse: assert property (@(posedge clk) disable iff (rst)
    sub_valid |=> !sub_valid);

  a_r8_oe_follows: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (rom_oe == $past(bus_own)));
endmodule

bind font_fetch_seq font_fetch_seq_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_own    (bus_own),
  .rom_oe     (rom_oe),
  .rom_rd_n   (rom_rd_n),
  .rom_addr   (rom_addr),
  .main_valid (main_valid),
  .sub_valid  (sub_valid)
);

// File: tb/sim_font_fetch_seq.sv
`timescale 1ns/1ps
module sim_font_fetch_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        main_req = 1'b0, sub_req = 1'b0, bus_own = 1'b1;
  logic [13:0] main_code = '0, sub_code = '0;
  logic [4:0]  main_raster = '0, sub_raster = '0;
  logic [7:0]  rom_data;
  logic [20:0] rom_addr;
  logic        rom_rd_n, rom_oe, main_valid, sub_valid;
  logic [23:0] main_pix, sub_pix;

  int checks = 0, fails = 0;
  int strobe_bad = 0, addr_bad = 0, nruns = 0, falls = 0, run = 0;
  logic [20:0] seen [64];
  logic [20:0] fall_addr = '0;
  logic        prev_rd = 1'b1;

  always #2 clk = ~clk;

  font_fetch_seq u0 (.*);

  function automatic logic [7:0] rom_fn(input logic [20:0] a);
    rom_fn = a[7:0] ^ a[15:8] ^ {1'b0, a[20:14]} ^ 8'h5A;
  endfunction
  assign rom_data = rom_fn(rom_addr);

  // address layout per R1/R2: {code[13:7], right, centre, code[6:0], raster}
  function automatic logic [20:0] ea(input logic [13:0] c, input logic [4:0] r, input int k);
    ea = {c[13:7], (k == 2), (k == 1), c[6:0], r};
  endfunction
  function automatic logic [23:0] exp_row(input logic [13:0] c, input logic [4:0] r);
    exp_row = {rom_fn(ea(c, r, 0)), rom_fn(ea(c, r, 1)), rom_fn(ea(c, r, 2))};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // strobe monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_rd && !rom_rd_n) begin
        seen[falls % 64] = rom_addr;
        falls++;
        run = 1;
        fall_addr = rom_addr;
      end else if (!rom_rd_n) begin
        run++;
        if (rom_addr != fall_addr) addr_bad++;
      end else if (!prev_rd) begin
        if (run != 3) strobe_bad++;
        nruns++;
      end
      prev_rd = rom_rd_n;
    end
  end

  task automatic drive(input bit lay, input logic [13:0] c, input logic [4:0] r);
    if (lay) begin sub_req = 1'b1; sub_code = c; sub_raster = r; end
    else     begin main_req = 1'b1; main_code = c; main_raster = r; end
  endtask

  // {layer, raster, code}
  localparam logic [19:0] VEC [8] = '{
    {1'b0, 5'd0,  14'h0000}, {1'b1, 5'd31, 14'h3FFF},
    {1'b0, 5'd17, 14'h2A55}, {1'b1, 5'd3,  14'h0080},
    {1'b0, 5'd31, 14'h007F}, {1'b1, 5'd9,  14'h1234},
    {1'b0, 5'd1,  14'h3F80}, {1'b1, 5'd22, 14'h0C3A}};

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R6 watchdog expired act=%0d exp=%0d", 20000, 0);
    finish_up();
  end

  initial begin
    int lat, lat_m, lat_s, base;
    logic [13:0] c; logic [4:0] r; bit lay;
    repeat (4) @(negedge clk);
    // R9 reset state
    chk(rom_rd_n == 1'b1, "R9 strobe in reset", 64'(rom_rd_n), 1);
    chk(rom_oe == 1'b0, "R9 oe in reset", 64'(rom_oe), 0);
    chk({main_valid, sub_valid} == 2'b00, "R9 valids in reset", 64'({main_valid, sub_valid}), 0);
    chk({main_pix, sub_pix} == 48'h0, "R9 pixels in reset", 64'({main_pix, sub_pix}), 0);
    rst = 1'b0;
    @(negedge clk);

    // table walk: R1 R2 R5 R6
    for (int i = 0; i < 8; i++) begin
      {lay, r, c} = VEC[i];
      repeat (i % 4 + 1) @(negedge clk);
      base = falls;
      drive(lay, c, r);
      @(negedge clk);
      main_req = 1'b0; sub_req = 1'b0;
      lat = 0;
      while (!(lay ? sub_valid : main_valid) && lat < 60) begin @(negedge clk); lat++; end
      chk(falls - base == 3 && seen[base % 64] == ea(c, r, 0) && seen[(base + 1) % 64] == ea(c, r, 1)
          && seen[(base + 2) % 64] == ea(c, r, 2), "R1 R2 address sequence",
          64'(seen[base % 64]), 64'(ea(c, r, 0)));
      chk((lay ? sub_pix : main_pix) == exp_row(c, r), "R5 row pixels",
          64'(lay ? sub_pix : main_pix), 64'(exp_row(c, r)));
      chk(lat >= 20 && lat <= 27, "R6 request latency", 64'(lat), 20);
    end

    // R4 both layers at once
    @(negedge clk);
    drive(1'b0, 14'h1111, 5'd5);
    drive(1'b1, 14'h2EE2, 5'd26);
    @(negedge clk);
    main_req = 1'b0; sub_req = 1'b0;
    lat = 0; lat_m = -1; lat_s = -1;
    while ((lat_m < 0 || lat_s < 0) && lat < 60) begin
      if (main_valid && lat_m < 0) lat_m = lat;
      if (sub_valid && lat_s < 0) lat_s = lat;
      @(negedge clk); lat++;
    end
    chk(main_pix == exp_row(14'h1111, 5'd5), "R4 main pixels", 64'(main_pix), 64'(exp_row(14'h1111, 5'd5)));
    chk(sub_pix == exp_row(14'h2EE2, 5'd26), "R4 sub pixels", 64'(sub_pix), 64'(exp_row(14'h2EE2, 5'd26)));
    chk(lat_m - lat_s == 4 || lat_s - lat_m == 4, "R4 valid spacing", 64'(lat_m - lat_s), 4);

    // R7 requests while busy, latest wins
    @(negedge clk);
    drive(1'b0, 14'h0AAA, 5'd7);
    @(negedge clk); main_req = 1'b0;
    repeat (3) @(negedge clk);
    drive(1'b0, 14'h0BBB, 5'd8);
    @(negedge clk);
    drive(1'b0, 14'h3CCC, 5'd12);
    @(negedge clk); main_req = 1'b0;
    lat = 0;
    while (!main_valid && lat < 60) begin @(negedge clk); lat++; end
    chk(main_pix == exp_row(14'h0AAA, 5'd7), "R7 first row", 64'(main_pix), 64'(exp_row(14'h0AAA, 5'd7)));
    @(negedge clk);
    lat = 0;
    while (!main_valid && lat < 60) begin @(negedge clk); lat++; end
    chk(main_pix == exp_row(14'h3CCC, 5'd12), "R7 latest request served", 64'(main_pix),
        64'(exp_row(14'h3CCC, 5'd12)));

    // R8 bus release during a fetch
    @(negedge clk);
    drive(1'b1, 14'h1357, 5'd19);
    @(negedge clk); sub_req = 1'b0; bus_own = 1'b0;
    @(negedge clk);
    chk(rom_oe == 1'b0, "R8 oe released", 64'(rom_oe), 0);
    lat = 0;
    while (!sub_valid && lat < 60) begin @(negedge clk); lat++; end
    chk(sub_pix == exp_row(14'h1357, 5'd19), "R8 fetch while released", 64'(sub_pix),
        64'(exp_row(14'h1357, 5'd19)));
    bus_own = 1'b1;
    @(negedge clk);
    chk(rom_oe == 1'b1, "R8 oe restored", 64'(rom_oe), 1);

    // R3 strobe shape over the whole run
    repeat (8) @(negedge clk);
    chk(strobe_bad == 0 && nruns > 0, "R3 strobe low width", 64'(strobe_bad), 0);
    chk(addr_bad == 0, "R3 address stable under strobe", 64'(addr_bad), 0);
    finish_up();
  end
endmodule